// File: doc/BRIEF.md
# Host mailbox console

This block gives a target processor with a 32-bit memory bus a pair of 64-bit mailbox registers for talking to a host: an outbound word (to-host) and an inbound word (from-host). The target composes each 64-bit request in two bus writes, lower word first, then upper word. The upper-word write commits the request. The block splits the committed word into a device selector, a command selector and a payload, and acts on it.

Three requests are served. The first is a test exit report carrying an exit code. The second is a console byte output. The third is a console read request. Answers go into the from-host register. A byte-wide console receive port and a byte-wide transmit strobe stand in for the host terminal, and an exit strobe with its code makes the test verdict visible to a simulation. The block acknowledges each request by clearing to-host to zero, which the target polls.

Top module: `hmb_console_top`

## Requirements
- R1: After a synchronous active-low reset, all four register words read zero, and `con_tx_valid`, `exit_valid` and `fromhost_busy` are low.
- R2: Reads are combinational on `bus_addr` (byte address). From-host low word is at 0x0, from-host high at 0x4, to-host low at 0x8 and to-host high at 0xC, and each returns its 32-bit half. Any other address reads zero, and writes to it change no register.
- R3: A to-host low-word write is taken only while to-host is all zero, and it loads to-host with the zero-extended data. Otherwise the write is dropped and the accept flag is cleared, so a following to-host high-word write is also dropped.
- R4: A to-host high-word write after an accepted low word commits the request. The request is the current to-host with the data ORed into bits 63:32: device = bits 63:56, command = bits 55:48, payload = bits 47:0. On the clock edge that takes the write, to-host becomes zero.
- R5: Device 0x01 with command 0x01 pulses `con_tx_valid` for one cycle, after the committing edge, with `con_tx_byte` = payload bits 7:0. From-host becomes {request bits 63:48, 48'h100 | byte}.
- R6: Device 0x00 with command 0x00 and payload bit 0 set pulses `exit_valid` for one cycle with `exit_code` = payload >> 1. From-host becomes {request bits 63:48, 48'h0}.
- R7: Any other committed request (including device 0x00, command 0x00 with payload bit 0 clear) produces no strobe. From-host becomes {request bits 63:48, 48'h0}.
- R8: Device 0x01 with command 0x00 stores the request as the pending read, leaves from-host unchanged and clears to-host.
- R9: A cycle with `con_rx_valid` high loads from-host with {pending-read bits 63:48, 48'h100 | `con_rx_byte`}, on the next edge. A from-host bus write in the same cycle takes priority.
- R10: A from-host low-word write replaces the register with the zero-extended data and raises `fromhost_busy`. A from-host high-word write ORs the data into bits 63:32 and lowers `fromhost_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current bus address |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| con_rx_valid | input | 1 | Console input byte present |
| con_rx_byte | input | 8 | Console input byte |
| con_tx_valid | output | 1 | One-cycle console output strobe |
| con_tx_byte | output | 8 | Console output byte |
| exit_valid | output | 1 | One-cycle exit-report strobe |
| exit_code | output | 47 | Reported exit code |
| fromhost_busy | output | 1 | From-host low word written, high word not yet |

## Verification
Every register update, strobe and acknowledge appears after the single clock edge that samples the bus write or console byte. Reads are combinational, so a read result is valid in the same cycle. The bench drives each input on a falling edge and holds it for one cycle. It checks strobes at the next falling edge, which is the only cycle they are high, and checks that they are low one cycle later. It reads registers after that edge, with a short settle delay after changing the address.

// File: rtl/hmb_pkg.sv
// Package: shared widths, field positions, selector codes and types for
// the host mailbox console. Assumes a 32-bit target bus and 64-bit words.
package hmb_pkg;

    localparam int BUS_W   = 32;
    localparam int WORD_W  = 2 * BUS_W;
    localparam int DEV_LSB = 56;
    localparam int CMD_LSB = 48;
    localparam int PAY_W   = 48;
    localparam int TAG_W   = WORD_W - PAY_W;
    localparam int CODE_W  = PAY_W - 1;

    localparam logic [7:0] DEV_SYS  = 8'h00;
    localparam logic [7:0] DEV_CON  = 8'h01;
    localparam logic [7:0] CMD_SYS_EXIT = 8'h00;
    localparam logic [7:0] CMD_CON_GET  = 8'h00;
    localparam logic [7:0] CMD_CON_PUT  = 8'h01;

    localparam logic [PAY_W-1:0] CON_TAG = PAY_W'(12'h100);

    // Action chosen for a committed request
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_EXIT   = 2'd1,
        ACT_PUTC   = 2'd2,
        ACT_GETREQ = 2'd3
    } act_e;

    // One bit per addressable 32-bit half
    typedef struct packed {
        logic th_hi;
        logic th_lo;
        logic fh_hi;
        logic fh_lo;
    } sel_t;

endpackage

// File: rtl/hmb_addr_map.sv
// Module: address decode and read multiplexer for the four register halves.
// Assumes byte addressing and that the two bases are distinct and 8-byte
// aligned; every other address decodes to nothing and reads zero.
module hmb_addr_map
    import hmb_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int FH_BASE = 0,
    parameter int TH_BASE = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] tohost,
    input  logic [WORD_W-1:0] fromhost,
    output sel_t              sel,
    output logic [BUS_W-1:0]  rdata
);

    localparam int NHALF = 4;

    logic [NHALF-1:0]           hit;
    logic [NHALF-1:0][BUS_W-1:0] half_val;

    // Byte offset of half h: 0 fh_lo, 1 fh_hi, 2 th_lo, 3 th_hi
    function automatic int half_ofs(input int h);
        return ((h < 2) ? FH_BASE : TH_BASE) + 4 * (h % 2);
    endfunction

    assign half_val[0] = fromhost[BUS_W-1:0];
    assign half_val[1] = fromhost[WORD_W-1:BUS_W];
    assign half_val[2] = tohost[BUS_W-1:0];
    assign half_val[3] = tohost[WORD_W-1:BUS_W];

    // One address comparator per half
    for (genvar h = 0; h < NHALF; h++) begin : g_cmp
        assign hit[h] = (bus_addr == ADDR_W'(half_ofs(h)));
    end

    assign sel = '{th_hi: hit[3], th_lo: hit[2], fh_hi: hit[1], fh_lo: hit[0]};

    // Read multiplexer: zero when no half matches
    always_comb begin
        rdata = '0;
        for (int h = 0; h < NHALF; h++) begin
            if (hit[h]) rdata = half_val[h];
        end
    end

endmodule

// File: rtl/hmb_cmd_exec.sv
// Module: combinational request decoder. Splits a committed 64-bit request
// into device, command and payload, picks the action and forms the 48-bit
// response and the strobe data. Assumes the request is stable while used.
module hmb_cmd_exec
    import hmb_pkg::*;
(
    input  logic [WORD_W-1:0] req,
    output act_e              act,
    output logic [PAY_W-1:0]  resp,
    output logic [7:0]        put_byte,
    output logic [CODE_W-1:0] code
);

    logic [7:0]       dev;
    logic [7:0]       cmd;
    logic [PAY_W-1:0] pay;

    assign dev = req[WORD_W-1:DEV_LSB];
    assign cmd = req[DEV_LSB-1:CMD_LSB];
    assign pay = req[PAY_W-1:0];

    assign put_byte = pay[7:0];
    assign code     = pay[PAY_W-1:1];

    // Action selection and response word
    always_comb begin
        act  = ACT_NONE;
        resp = '0;
        if (dev == DEV_SYS && cmd == CMD_SYS_EXIT && pay[0]) begin
            act = ACT_EXIT;
        end else if (dev == DEV_CON && cmd == CMD_CON_PUT) begin
            act  = ACT_PUTC;
            resp = CON_TAG | PAY_W'(pay[7:0]);
        end else if (dev == DEV_CON && cmd == CMD_CON_GET) begin
            act = ACT_GETREQ;
        end
    end

endmodule

// File: rtl/hmb_console_top.sv
// Module: host mailbox console top. Holds the to-host and from-host words,
// the pending console read, the low-word accept flag and the from-host
// partial-write flag. Every state change takes one clock edge; reads are
// combinational. Assumes at most one bus write per cycle and no
// backpressure on the console output or exit strobes.
module hmb_console_top
    import hmb_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int FH_BASE = 0,
    parameter int TH_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              con_rx_valid,
    input  logic [7:0]        con_rx_byte,
    output logic              con_tx_valid,
    output logic [7:0]        con_tx_byte,
    output logic              exit_valid,
    output logic [46:0]       exit_code,
    output logic              fromhost_busy
);

    logic [WORD_W-1:0] tohost_q,  tohost_d;
    logic [WORD_W-1:0] fromhost_q, fromhost_d;
    logic [WORD_W-1:0] pend_q,    pend_d;
    logic              allow_q,   allow_d;
    logic              busy_q,    busy_d;
    logic              tx_v_q,    tx_v_d;
    logic [7:0]        tx_b_q,    tx_b_d;
    logic              ex_v_q,    ex_v_d;
    logic [CODE_W-1:0] ex_c_q,    ex_c_d;

    sel_t              sel;
    logic              wr_th_lo, wr_th_hi, wr_fh_lo, wr_fh_hi;
    logic              commit;
    logic [WORD_W-1:0] req_word;
    act_e              act;
    logic [PAY_W-1:0]  resp;
    logic [7:0]        put_byte;
    logic [CODE_W-1:0] code;

    hmb_addr_map #(
        .ADDR_W  (ADDR_W),
        .FH_BASE (FH_BASE),
        .TH_BASE (TH_BASE)
    ) u_map (
        .bus_addr (bus_addr),
        .tohost   (tohost_q),
        .fromhost (fromhost_q),
        .sel      (sel),
        .rdata    (bus_rdata)
    );

    assign wr_th_lo = bus_we & sel.th_lo;
    assign wr_th_hi = bus_we & sel.th_hi;
    assign wr_fh_lo = bus_we & sel.fh_lo;
    assign wr_fh_hi = bus_we & sel.fh_hi;

    // Full request as it stands once the high word is merged in
    assign req_word = {tohost_q[WORD_W-1:BUS_W] | bus_wdata, tohost_q[BUS_W-1:0]};
    assign commit   = wr_th_hi & allow_q;

    hmb_cmd_exec u_exec (
        .req      (req_word),
        .act      (act),
        .resp     (resp),
        .put_byte (put_byte),
        .code     (code)
    );

    // Next-state logic for the mailbox words, flags and strobes
    always_comb begin
        tohost_d   = tohost_q;
        fromhost_d = fromhost_q;
        pend_d     = pend_q;
        allow_d    = allow_q;
        busy_d     = busy_q;
        tx_v_d     = 1'b0;
        tx_b_d     = tx_b_q;
        ex_v_d     = 1'b0;
        ex_c_d     = ex_c_q;

        if (con_rx_valid) begin
            fromhost_d = {pend_q[WORD_W-1:PAY_W], CON_TAG | PAY_W'(con_rx_byte)};
        end

        if (wr_th_lo) begin
            if (tohost_q == '0) begin
                allow_d  = 1'b1;
                tohost_d = WORD_W'(bus_wdata);
            end else begin
                allow_d  = 1'b0;
            end
        end

        if (commit) begin
            tohost_d = '0;
            unique case (act)
                ACT_GETREQ: pend_d = req_word;
                ACT_PUTC: begin
                    tx_v_d = 1'b1;
                    tx_b_d = put_byte;
                end
                ACT_EXIT: begin
                    ex_v_d = 1'b1;
                    ex_c_d = code;
                end
                default: ;
            endcase
            if (act != ACT_GETREQ) begin
                fromhost_d = {req_word[WORD_W-1:PAY_W], resp};
            end
        end

        if (wr_fh_lo) begin
            fromhost_d = WORD_W'(bus_wdata);
            busy_d     = 1'b1;
        end else if (wr_fh_hi) begin
            fromhost_d = {fromhost_q[WORD_W-1:BUS_W] | bus_wdata, fromhost_q[BUS_W-1:0]};
            busy_d     = 1'b0;
        end
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tohost_q   <= '0;
            fromhost_q <= '0;
            pend_q     <= '0;
            allow_q    <= 1'b0;
            busy_q     <= 1'b0;
            tx_v_q     <= 1'b0;
            tx_b_q     <= '0;
            ex_v_q     <= 1'b0;
            ex_c_q     <= '0;
        end else begin
            tohost_q   <= tohost_d;
            fromhost_q <= fromhost_d;
            pend_q     <= pend_d;
            allow_q    <= allow_d;
            busy_q     <= busy_d;
            tx_v_q     <= tx_v_d;
            tx_b_q     <= tx_b_d;
            ex_v_q     <= ex_v_d;
            ex_c_q     <= ex_c_d;
        end
    end

    assign con_tx_valid  = tx_v_q;
    assign con_tx_byte   = tx_b_q;
    assign exit_valid    = ex_v_q;
    assign exit_code     = ex_c_q;
    assign fromhost_busy = busy_q;

    AST_REJECT_KEEPS_TOHOST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_th_lo && tohost_q != '0) |=> (tohost_q == $past(tohost_q))) else $error("AST_REJECT_KEEPS_TOHOST"); // R3

    AST_COMMIT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (tohost_q == '0)) else $error("AST_COMMIT_ACKS"); // R4

    AST_TX_FROM_HIGH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        con_tx_valid |-> $past(wr_th_hi)) else $error("AST_TX_FROM_HIGH_WRITE"); // R5

    AST_EXIT_FROM_HIGH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |-> $past(wr_th_hi)) else $error("AST_EXIT_FROM_HIGH_WRITE"); // R6

    AST_RX_LOADS_FROMHOST: assert property (@(posedge clk) disable iff (!rst_n)
        (con_rx_valid && !commit && !wr_fh_lo && !wr_fh_hi)
        |=> (fromhost_q[PAY_W-1:0] == (CON_TAG | PAY_W'($past(con_rx_byte))))) else $error("AST_RX_LOADS_FROMHOST"); // R9

    AST_BUSY_ON_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fh_lo |=> fromhost_busy) else $error("AST_BUSY_ON_LOW_WRITE"); // R10

endmodule

// File: tb/hmb_console_top_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module hmb_console_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_FH_LO = 4'h0;
    localparam logic [3:0] A_FH_HI = 4'h4;
    localparam logic [3:0] A_TH_LO = 4'h8;
    localparam logic [3:0] A_TH_HI = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        con_rx_valid = 1'b0;
    logic [7:0]  con_rx_byte = '0;
    logic        con_tx_valid;
    logic [7:0]  con_tx_byte;
    logic        exit_valid;
    logic [46:0] exit_code;
    logic        fromhost_busy;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hmb_console_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .con_rx_valid  (con_rx_valid),
        .con_rx_byte   (con_rx_byte),
        .con_tx_valid  (con_tx_valid),
        .con_tx_byte   (con_tx_byte),
        .exit_valid    (exit_valid),
        .exit_code     (exit_code),
        .fromhost_busy (fromhost_busy)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Ends on the falling edge after the capturing rising edge
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rx_byte(input logic [7:0] b);
        @(negedge clk);
        con_rx_valid = 1'b1; con_rx_byte = b;
        @(negedge clk);
        con_rx_valid = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        check(req, 64'(d), 64'(exp));
    endtask

    task automatic t_reset();
        do_reset();
        chk_reg("R1 fh_lo", A_FH_LO, 32'h0);
        chk_reg("R1 fh_hi", A_FH_HI, 32'h0);
        chk_reg("R1 th_lo", A_TH_LO, 32'h0);
        chk_reg("R1 th_hi", A_TH_HI, 32'h0);
        check("R1 strobes", {61'h0, con_tx_valid, exit_valid, fromhost_busy}, 64'h0);
    endtask

    task automatic t_putc();
        do_reset();
        bus_wr(A_TH_LO, 32'h0000_0041);
        chk_reg("R3 accepted low", A_TH_LO, 32'h0000_0041);
        bus_wr(A_TH_HI, 32'h0101_0000);
        check("R5 tx strobe", 64'(con_tx_valid), 64'h1);
        check("R5 tx byte", 64'(con_tx_byte), 64'h41);
        check("R5 no exit", 64'(exit_valid), 64'h0);
        chk_reg("R4 th_lo cleared", A_TH_LO, 32'h0);
        chk_reg("R4 th_hi cleared", A_TH_HI, 32'h0);
        chk_reg("R5 fh_lo resp", A_FH_LO, 32'h0000_0141);
        chk_reg("R5 fh_hi tag", A_FH_HI, 32'h0101_0000);
        @(negedge clk);
        check("R5 tx one cycle", 64'(con_tx_valid), 64'h0);
    endtask

    task automatic t_exit();
        do_reset();
        bus_wr(A_TH_LO, 32'h0000_0055);
        bus_wr(A_TH_HI, 32'h0000_0001);
        check("R6 exit strobe", 64'(exit_valid), 64'h1);
        check("R6 exit code", 64'(exit_code), 64'h0000_8000_002A);
        check("R6 no tx", 64'(con_tx_valid), 64'h0);
        chk_reg("R6 fh_lo", A_FH_LO, 32'h0);
        chk_reg("R6 fh_hi", A_FH_HI, 32'h0);
        chk_reg("R4 th_lo", A_TH_LO, 32'h0);
        @(negedge clk);
        check("R6 exit one cycle", 64'(exit_valid), 64'h0);
    endtask

    task automatic t_unknown();
        do_reset();
        bus_wr(A_FH_LO, 32'hFFFF_FFFF);
        bus_wr(A_TH_LO, 32'h0000_1234);
        bus_wr(A_TH_HI, 32'h0705_0000);
        check("R7 no strobes", {62'h0, con_tx_valid, exit_valid}, 64'h0);
        chk_reg("R7 fh_lo zeroed", A_FH_LO, 32'h0);
        chk_reg("R7 fh_hi tag", A_FH_HI, 32'h0705_0000);
        chk_reg("R7 th acked", A_TH_LO, 32'h0);
        bus_wr(A_TH_LO, 32'h0000_0002);
        bus_wr(A_TH_HI, 32'h0000_0000);
        check("R7 even exit bit", {62'h0, con_tx_valid, exit_valid}, 64'h0);
        chk_reg("R7 fh_hi sys", A_FH_HI, 32'h0);
    endtask

    task automatic t_getc();
        do_reset();
        bus_wr(A_FH_LO, 32'h0000_DEAD);
        bus_wr(A_FH_HI, 32'h0);
        bus_wr(A_TH_LO, 32'h0000_0000);
        bus_wr(A_TH_HI, 32'h0100_0000);
        check("R8 no tx", 64'(con_tx_valid), 64'h0);
        chk_reg("R8 fh_lo kept", A_FH_LO, 32'h0000_DEAD);
        chk_reg("R8 fh_hi kept", A_FH_HI, 32'h0);
        chk_reg("R8 th cleared", A_TH_HI, 32'h0);
        rx_byte(8'h7A);
        chk_reg("R9 fh_lo char", A_FH_LO, 32'h0000_017A);
        chk_reg("R9 fh_hi tag", A_FH_HI, 32'h0100_0000);
    endtask

    task automatic t_fh_direct();
        do_reset();
        bus_wr(A_FH_LO, 32'hCAFE_0001);
        check("R10 busy set", 64'(fromhost_busy), 64'h1);
        chk_reg("R10 lo", A_FH_LO, 32'hCAFE_0001);
        chk_reg("R10 hi zero", A_FH_HI, 32'h0);
        bus_wr(A_FH_HI, 32'h0000_00F0);
        check("R10 busy clear", 64'(fromhost_busy), 64'h0);
        bus_wr(A_FH_HI, 32'h0000_0F00);
        chk_reg("R10 hi ored", A_FH_HI, 32'h0000_0FF0);
        chk_reg("R10 lo kept", A_FH_LO, 32'hCAFE_0001);
    endtask

    task automatic t_unmapped();
        do_reset();
        bus_wr(A_FH_LO, 32'h1111_2222);
        bus_wr(4'h2, 32'hFFFF_FFFF);
        bus_wr(4'h9, 32'hFFFF_FFFF);
        chk_reg("R2 unmapped read", 4'h2, 32'h0);
        chk_reg("R2 misaligned read", 4'h1, 32'h0);
        chk_reg("R2 fh_lo intact", A_FH_LO, 32'h1111_2222);
        chk_reg("R2 fh_hi intact", A_FH_HI, 32'h0);
        chk_reg("R2 th_lo intact", A_TH_LO, 32'h0);
        check("R2 busy intact", 64'(fromhost_busy), 64'h1);
    endtask

    task automatic t_reject();
        do_reset();
        bus_wr(A_TH_LO, 32'h0000_0011);
        bus_wr(A_TH_LO, 32'h0000_0022);
        chk_reg("R3 second low dropped", A_TH_LO, 32'h0000_0011);
        bus_wr(A_TH_HI, 32'h0101_0000);
        check("R3 high dropped no tx", 64'(con_tx_valid), 64'h0);
        chk_reg("R3 high dropped", A_TH_HI, 32'h0);
        chk_reg("R3 low kept", A_TH_LO, 32'h0000_0011);
        chk_reg("R3 fh untouched", A_FH_LO, 32'h0);
    endtask

    initial begin
        t_reset();
        t_putc();
        t_exit();
        t_unknown();
        t_getc();
        t_fh_direct();
        t_unmapped();
        t_reject();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule